// File: doc/BRIEF.md
# Programmable-Timing External Bus Controller

This block masters an asynchronous external bus on behalf of an internal host. It takes one read or write request at a time and turns it into pin-level activity: a 9-bit address, a 16-bit data bus split into input, output and output-enable, active-low output-enable, write-enable and address-valid strobes, and six active-low chip selects. Each chip select has its own timing profile, so slow and fast devices can share the same pins.

Timing profiles are loaded through a plain register-write port, one 39-bit word per chip select. A profile sets the read and write strobe wait counts, the write hold count, the read setup count, the address-valid-to-strobe delay, an optional extra address-hold cycle, a first-access latency per direction, and a recovery count. The first-access latency is added only when an access opens a new page. The recovery gap is added only when a read is followed by a write, or by any access to another chip select.

The host request side uses valid/ready. A request must hold its valid and all request fields stable until it sees ready high at a rising edge. Ready is high only when the controller is idle and the presented request needs no recovery gap, so the controller applies back-pressure for the whole access and for any gap. Read data returns on a response pulse that has no back-pressure: the host must take it in the cycle it appears.

Top module: `ebc_top`

## Requirements
- R1: During and directly after reset, all chip selects and strobes are high, the data enable is low, ready is high and no response is pending. The reset profile of every chip select is all zeros.
- R2: A request is taken at a rising edge where req_valid and req_ready are both high. Ready is high only when the controller is idle. In the cycle after the request is taken, the address-valid strobe is low and the chosen chip select is low.
- R3: A read drives its chip select low and its address for these cycles, in order: 1 address-valid cycle, 1 extra cycle if the address-hold flag is set, then read-setup + adv-to-OE (+ read first-access latency) cycles, then OE low for read-wait+1 cycles. When no access is running, the address and data outputs are zero.
- R4: Read data is sampled on bus_din at the end of the last OE-low cycle. It is returned in the next cycle, with rsp_valid high for exactly that one cycle.
- R5: A write runs 1 address-valid cycle, 1 optional address-hold cycle, the write first-access latency cycles, WE low for write-wait+1 cycles, and then write-hold+1 cycles with WE high and the chip select still low. OE and WE are never low together.
- R6: An access is first-in-page when it is the first access since reset, or when its chip select or its address bits 8..4 differ from those of the previous access. Only a first-in-page access adds its direction's first-access latency.
- R7: When the last access was a read and the presented request is a write, or targets another chip select, ready is held low for max(1, recovery) cycles. The recovery count is the one of the chip select that did the read. No gap is added in any other case.
- R8: cfg_we writes cfg_data into the profile of chip select cfg_cs. The fields are, from bit 38 down: address-hold[38], adv-to-OE[37:36], read setup[35:32], read latency[31:24], write latency[23:16], recovery[15:12], write hold[11:8], write wait[7:4], read wait[3:0]. At most one chip select is low at any time.
- R9: bus_doe is high only during the WE-low cycles and the write-hold cycles of a write. While it is high, bus_dout carries the request's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Profile write strobe |
| cfg_cs | input | 3 | Chip select whose profile is written |
| cfg_data | input | 39 | Profile word (fields per R8) |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Target chip select, 0 to 5 |
| req_addr | input | 9 | Word address on the external bus |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 16 | Read data |
| bus_addr | output | 9 | External address |
| bus_dout | output | 16 | External data out |
| bus_din | input | 16 | External data in |
| bus_doe | output | 1 | Data output enable for the pad tristate |
| bus_oe_n | output | 1 | Output-enable strobe, active low |
| bus_we_n | output | 1 | Write-enable strobe, active low |
| bus_adv_n | output | 1 | Address-valid strobe, active low |
| bus_cs_n | output | 6 | Chip selects, active low |

## Verification
The assertions assume the host keeps req_cs between 0 and 5 and holds a request steady while ready is low. Under that assumption, the one-hot chip select check and the address-valid-after-accept check can rely on the chip select index. The stimulus draws chip selects only from 0 to 5, changes request fields only after an acceptance edge, and writes profiles only while no request is pending. Because of this, a profile never changes between acceptance and the recovery decision that reads it.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int WAIT_W  = 4;
  localparam int DELTA_W = 8;
  localparam int ADVOE_W = 2;
  localparam int CNT_W   = $clog2((2**WAIT_W) + (2**ADVOE_W) + (2**DELTA_W));

  typedef struct packed {
    logic               addr_hold;
    logic [ADVOE_W-1:0] adv_oe;
    logic [WAIT_W-1:0]  rd_setup;
    logic [DELTA_W-1:0] rd_lat;
    logic [DELTA_W-1:0] wr_lat;
    logic [WAIT_W-1:0]  recov;
    logic [WAIT_W-1:0]  wr_hold;
    logic [WAIT_W-1:0]  wr_wait;
    logic [WAIT_W-1:0]  rd_wait;
  } ebc_prof_t;

  localparam int PROF_W = $bits(ebc_prof_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADV, ST_AHOLD, ST_SETUP, ST_STROBE, ST_WHOLD, ST_RECOV
  } ebc_state_e;
endpackage

// File: rtl/ebc_prof_bank.sv
module ebc_prof_bank
  import ebc_pkg::*;
#(
  parameter int NCS = 6,
  localparam int SW = $clog2(NCS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SW-1:0]         wr_sel,
  input  logic [PROF_W-1:0]     wr_data,
  input  logic [SW-1:0]         sel_req,
  input  logic [SW-1:0]         sel_last,
  output ebc_prof_t             prof_req,
  output logic [WAIT_W-1:0]     recov_last
);
  ebc_prof_t bank [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_prof
    ebc_prof_t prof_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             prof_q <= '0;
      else if (wr_en && wr_sel == SW'(g))     prof_q <= ebc_prof_t'(wr_data);
    end
    assign bank[g] = prof_q;
  end

  always_comb begin
    prof_req   = '0;
    recov_last = '0;
    for (int i = 0; i < NCS; i++) begin
      if (sel_req == SW'(i))  prof_req   = bank[i];
      if (sel_last == SW'(i)) recov_last = bank[i].recov;
    end
  end
endmodule

// File: rtl/ebc_track.sv
module ebc_track #(
  parameter int NCS      = 6,
  parameter int AW       = 9,
  parameter int PAGE_LSB = 4,
  localparam int SW      = $clog2(NCS),
  localparam int TAG_W   = AW - PAGE_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] q_cs,
  input  logic [AW-1:0] q_addr,
  input  logic          q_write,
  input  logic          take,
  input  logic          gap_done,
  output logic          first_o,
  output logic          gap_o,
  output logic [SW-1:0] last_cs_o
);
  logic             seen_q;
  logic [SW-1:0]    cs_q;
  logic [TAG_W-1:0] tag_q;
  logic             rd_pend_q;

  assign first_o   = !seen_q || (q_cs != cs_q) || (q_addr[AW-1:PAGE_LSB] != tag_q);
  assign gap_o     = rd_pend_q && (q_write || (q_cs != cs_q));
  assign last_cs_o = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      cs_q      <= '0;
      tag_q     <= '0;
      rd_pend_q <= 1'b0;
    end else if (take) begin
      seen_q    <= 1'b1;
      cs_q      <= q_cs;
      tag_q     <= q_addr[AW-1:PAGE_LSB];
      rd_pend_q <= !q_write;
    end else if (gap_done) begin
      rd_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int NCS = 6,
  parameter int AW  = 9,
  parameter int DW  = 16,
  localparam int SW = $clog2(NCS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SW-1:0]     req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  ebc_prof_t         prof,
  input  logic [WAIT_W-1:0] recov,
  input  logic              first,
  input  logic              gap,
  input  logic [DW-1:0]     bus_din,
  output logic              req_ready,
  output logic              take,
  output logic              gap_done,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic              bus_adv_n,
  output logic [NCS-1:0]    bus_cs_n
);
  ebc_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  setup_q;
  logic [WAIT_W-1:0] strobe_q, hold_q;
  logic              wr_q, ah_q;
  logic [SW-1:0]     cs_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;
  logic [CNT_W-1:0]  setup_new;
  logic [WAIT_W-1:0] rec_len;
  logic              busy;

  assign req_ready = (state == ST_IDLE) && !(gap && req_valid);
  assign take      = req_ready && req_valid;
  assign gap_done  = (state == ST_IDLE) && gap && req_valid;
  assign rec_len   = (recov == '0) ? WAIT_W'(1) : recov;

  always_comb begin
    if (req_write)
      setup_new = first ? CNT_W'(prof.wr_lat) : '0;
    else
      setup_new = CNT_W'(prof.rd_setup) + CNT_W'(prof.adv_oe)
                + (first ? CNT_W'(prof.rd_lat) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      setup_q   <= '0;
      strobe_q  <= '0;
      hold_q    <= '0;
      wr_q      <= 1'b0;
      ah_q      <= 1'b0;
      cs_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (gap_done) begin
            if (rec_len > WAIT_W'(1)) begin
              state <= ST_RECOV;
              cnt   <= CNT_W'(rec_len - WAIT_W'(2));
            end
          end else if (take) begin
            state    <= ST_ADV;
            wr_q     <= req_write;
            cs_q     <= req_cs;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            ah_q     <= prof.addr_hold;
            setup_q  <= setup_new;
            strobe_q <= req_write ? prof.wr_wait : prof.rd_wait;
            hold_q   <= prof.wr_hold;
          end
        end
        ST_RECOV: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_ADV, ST_AHOLD: begin
          if (state == ST_ADV && ah_q) begin
            state <= ST_AHOLD;
          end else if (setup_q == '0) begin
            state <= ST_STROBE;
            cnt   <= CNT_W'(strobe_q);
          end else begin
            state <= ST_SETUP;
            cnt   <= setup_q - 1'b1;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_STROBE;
            cnt   <= CNT_W'(strobe_q);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (wr_q) begin
            state <= ST_WHOLD;
            cnt   <= CNT_W'(hold_q);
          end else begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= bus_din;
          end
        end
        ST_WHOLD: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE) && (state != ST_RECOV);
  assign bus_adv_n = (state != ST_ADV);
  assign bus_oe_n  = !((state == ST_STROBE) && !wr_q);
  assign bus_we_n  = !((state == ST_STROBE) && wr_q);
  assign bus_doe   = wr_q && ((state == ST_STROBE) || (state == ST_WHOLD));
  assign bus_addr  = busy ? addr_q : '0;
  assign bus_dout  = bus_doe ? wdata_q : '0;

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign bus_cs_n[g] = !(busy && (cs_q == SW'(g)));
  end
endmodule

// File: rtl/ebc_top.sv
module ebc_top
  import ebc_pkg::*;
#(
  parameter int NCS = 6,
  parameter int AW  = 9,
  parameter int DW  = 16,
  localparam int SW = $clog2(NCS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SW-1:0]     cfg_cs,
  input  logic [PROF_W-1:0] cfg_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [SW-1:0]     req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [AW-1:0]     bus_addr,
  output logic [DW-1:0]     bus_dout,
  input  logic [DW-1:0]     bus_din,
  output logic              bus_doe,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic              bus_adv_n,
  output logic [NCS-1:0]    bus_cs_n
);
  ebc_prof_t         prof_req;
  logic [WAIT_W-1:0] recov_last;
  logic [SW-1:0]     last_cs;
  logic              first, gap, take, gap_done;

  ebc_prof_bank #(.NCS(NCS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_cs), .wr_data(cfg_data),
    .sel_req(req_cs), .sel_last(last_cs), .prof_req(prof_req), .recov_last(recov_last)
  );

  ebc_track #(.NCS(NCS), .AW(AW)) u_track (
    .clk(clk), .rst_n(rst_n), .q_cs(req_cs), .q_addr(req_addr), .q_write(req_write),
    .take(take), .gap_done(gap_done), .first_o(first), .gap_o(gap), .last_cs_o(last_cs)
  );

  ebc_seq #(.NCS(NCS), .AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata), .prof(prof_req),
    .recov(recov_last), .first(first), .gap(gap), .bus_din(bus_din),
    .req_ready(req_ready), .take(take), .gap_done(gap_done),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_adv_n(bus_adv_n), .bus_cs_n(bus_cs_n)
  );
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
  parameter int NCS = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           bus_doe,
  input logic           bus_oe_n,
  input logic           bus_we_n,
  input logic           bus_adv_n,
  input logic [NCS-1:0] bus_cs_n
);
  p_cs_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&bus_cs_n));

  p_adv_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!bus_adv_n && !(&bus_cs_n)));

  p_adv_has_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_adv_n |-> !(&bus_cs_n));

  p_rsp_after_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!bus_oe_n));

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_no_oe_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));

  p_doe_no_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (bus_oe_n && !(&bus_cs_n)));

  p_we_has_doe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> bus_doe);
endmodule

bind ebc_top ebc_checker #(.NCS(NCS)) u_ebc_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .bus_doe(bus_doe), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
  .bus_adv_n(bus_adv_n), .bus_cs_n(bus_cs_n)
);

// File: tb/test_ebc_top.sv
`timescale 1ns/1ps
module test_ebc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_cs = '0;
  logic [38:0] cfg_data = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_cs = '0;
  logic [8:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [8:0]  bus_addr;
  logic [15:0] bus_dout, bus_din;
  logic        bus_doe, bus_oe_n, bus_we_n, bus_adv_n;
  logic [5:0]  bus_cs_n;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] dev_data(logic [8:0] a);
    return {a[6:0] ^ 7'h35, a};
  endfunction

  assign bus_din = bus_oe_n ? 16'h0 : dev_data(bus_addr);

  ebc_top i_ebc_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din), .bus_doe(bus_doe),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_adv_n(bus_adv_n), .bus_cs_n(bus_cs_n)
  );

  typedef struct packed {
    logic [5:0]  cs_n;
    logic        adv_n, oe_n, we_n, doe;
    logic [8:0]  addr;
    logic [15:0] dout;
    logic        cap;
  } exp_t;

  exp_t q[$];
  int m_rdw[6], m_wrw[6], m_wrh[6], m_rec[6], m_rdl[6], m_wrl[6], m_rds[6], m_aoe[6], m_ah[6];
  bit m_pend = 0, m_seen = 0, rsp_due = 0;
  int m_last = 0, m_tag = 0;
  logic [15:0] rsp_exp = '0;

  task automatic check(bit ok, string tag, string what, int got, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic exp_t idle_item();
    exp_t e;
    e = '0; e.cs_n = 6'h3f; e.adv_n = 1; e.oe_n = 1; e.we_n = 1;
    return e;
  endfunction

  function automatic exp_t act_item(int cs, int a);
    exp_t e;
    e = idle_item(); e.cs_n = ~(6'b1 << cs); e.addr = a[8:0];
    return e;
  endfunction

  task automatic model_take(bit w, int cs, int a, int d);
    exp_t e;
    bit first;
    int setup;
    first = !m_seen || cs != m_last || (a >> 4) != m_tag;   // R6 page rule
    m_seen = 1; m_last = cs; m_tag = a >> 4; m_pend = !w;
    e = act_item(cs, a); e.adv_n = 0; q.push_back(e);
    if (m_ah[cs] != 0) q.push_back(act_item(cs, a));
    setup = w ? (first ? m_wrl[cs] : 0) : m_rds[cs] + m_aoe[cs] + (first ? m_rdl[cs] : 0);
    repeat (setup) q.push_back(act_item(cs, a));
    if (w) begin   // R5 and R9
      for (int i = 0; i <= m_wrw[cs]; i++) begin
        e = act_item(cs, a); e.we_n = 0; e.doe = 1; e.dout = d[15:0]; q.push_back(e);
      end
      for (int i = 0; i <= m_wrh[cs]; i++) begin
        e = act_item(cs, a); e.doe = 1; e.dout = d[15:0]; q.push_back(e);
      end
    end else begin // R3
      for (int i = 0; i <= m_rdw[cs]; i++) begin
        e = act_item(cs, a); e.oe_n = 0; e.cap = (i == m_rdw[cs]); q.push_back(e);
      end
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    bit exp_rdy, gapn;
    int n;
    if (rst_n && !done) begin
      if (q.size() > 0) begin
        e = q.pop_front(); exp_rdy = 0;
      end else begin
        e = idle_item();
        gapn = m_pend && req_valid && (req_write || int'(req_cs) != m_last);
        exp_rdy = !gapn;
        if (gapn) begin  // R7 recovery gap
          m_pend = 0;
          n = (m_rec[m_last] == 0) ? 1 : m_rec[m_last];
          repeat (n - 1) q.push_back(idle_item());
        end else if (req_valid) begin
          model_take(req_write, int'(req_cs), int'(req_addr), int'(req_wdata));
        end
      end
      check(req_ready == exp_rdy, "R2 R7", "req_ready", req_ready, exp_rdy);
      check(bus_cs_n == e.cs_n, "R8", "bus_cs_n", bus_cs_n, e.cs_n);
      check(bus_adv_n == e.adv_n, "R3", "bus_adv_n", bus_adv_n, e.adv_n);
      check(bus_oe_n == e.oe_n, "R3 R6", "bus_oe_n", bus_oe_n, e.oe_n);
      check(bus_we_n == e.we_n, "R5", "bus_we_n", bus_we_n, e.we_n);
      check(bus_doe == e.doe, "R9", "bus_doe", bus_doe, e.doe);
      check(bus_addr == e.addr, "R3", "bus_addr", bus_addr, e.addr);
      check(bus_dout == e.dout, "R9", "bus_dout", bus_dout, e.dout);
      check(rsp_valid == rsp_due, "R4", "rsp_valid", rsp_valid, rsp_due);
      if (rsp_due) check(rsp_rdata == rsp_exp, "R4", "rsp_rdata", rsp_rdata, rsp_exp);
      rsp_due = e.cap;
      rsp_exp = dev_data(e.addr);
    end
  end

  task automatic set_prof(int cs, int rdw, int wrw, int wrh, int rec, int rdl, int wrl,
                          int rds, int aoe, int ah);
    m_rdw[cs] = rdw; m_wrw[cs] = wrw; m_wrh[cs] = wrh; m_rec[cs] = rec; m_rdl[cs] = rdl;
    m_wrl[cs] = wrl; m_rds[cs] = rds; m_aoe[cs] = aoe; m_ah[cs] = ah;
    @(posedge clk); #1;
    cfg_we = 1; cfg_cs = cs[2:0];
    cfg_data = {1'(ah), 2'(aoe), 4'(rds), 8'(rdl), 8'(wrl), 4'(rec), 4'(wrh), 4'(wrw), 4'(rdw)};
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic issue(bit w, int cs, int a, int d);
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_cs = cs[2:0]; req_addr = a[8:0]; req_wdata = d[15:0];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    fails++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 6; i++) begin
      m_rdw[i] = 0; m_wrw[i] = 0; m_wrh[i] = 0; m_rec[i] = 0; m_rdl[i] = 0;
      m_wrl[i] = 0; m_rds[i] = 0; m_aoe[i] = 0; m_ah[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check(bus_cs_n == 6'h3f && bus_adv_n && bus_oe_n && bus_we_n && !bus_doe,
          "R1", "pins in reset", {bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n, bus_doe}, 10'h3fe);
    check(!rsp_valid, "R1", "rsp_valid in reset", rsp_valid, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check(req_ready, "R1", "ready after reset", req_ready, 1);

    // R1: chip select 0 keeps the all-zero reset profile
    issue(0, 0, 'h010, 0);
    issue(0, 0, 'h012, 0);          // same page, no latency (R6)
    issue(1, 0, 'h013, 'hbeef);     // read then write: gap of 1 (R7)
    // R8: profile loads
    set_prof(1, 2, 1, 2, 3, 5, 4, 1, 2, 1);
    set_prof(2, 3, 0, 0, 0, 20, 0, 0, 0, 0);
    set_prof(3, 1, 2, 0, 15, 0, 0, 15, 3, 0);
    set_prof(4, 0, 0, 15, 7, 255, 255, 0, 1, 1);
    set_prof(5, 9, 9, 3, 0, 28, 31, 0, 0, 0);
    issue(0, 1, 'h020, 0);          // first in page, address hold (R3 R6)
    issue(0, 1, 'h021, 0);          // same cs, same page: no gap (R7)
    issue(0, 2, 'h022, 0);          // other cs after read: gap 3 (R7)
    issue(0, 2, 'h0a0, 0);          // new page same cs (R6)
    issue(1, 5, 'h100, 'h1234);     // other cs after read, rec 0 -> 1 (R7)
    issue(1, 5, 'h101, 'h5678);     // write after write: no gap (R5)
    issue(0, 5, 'h102, 0);
    issue(0, 3, 'h1ff, 0);          // max setup and adv delay (R3)
    issue(1, 3, 'h1f0, 'h0f0f);     // read then write same cs: gap 15 (R7)
    issue(1, 4, 'h040, 'haaaa);     // max latency, max hold (R5 R6)
    issue(0, 4, 'h041, 0);
    issue(0, 4, 'h050, 0);
    lfsr = 16'hace1;
    for (int k = 0; k < 70; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(lfsr[0], int'(lfsr[3:1]) % 6, int'(lfsr[12:4]) & 'h13f, int'(lfsr));
    end
    while (q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule